// File: doc/BRIEF.md
# Reference Edge Timestamper

This block stamps the rising edges of an asynchronous reference input with the value of a local free-running counter. The counter advances once every `cfg_prescale + 1` clocks and returns to zero after it reaches `cfg_limit`. Each detected rising edge copies the counter into a capture register and raises a valid flag. Software or a hardware consumer polls that flag and takes the value with a one-cycle read strobe.

If a second edge arrives while the earlier timestamp is still unread, the older value is lost. A sticky over-capture flag reports that loss. The flag stays set until an explicit clear, so a consumer that is too slow cannot miss it. The reference input crosses into the clock domain through a two-flop synchronizer and then an edge detector. The capture therefore trails the input by a fixed three clocks.

Top module: `ref_edge_timestamper`

## Requirements
- R1: While reset is asserted and right after it, `stamp_valid` is 0, `over_capture` is 0 and `stamp_value` is 0.
- R2: Only a low-to-high transition of `ref_in` produces a timestamp. A falling edge, or a level held high for any length of time, produces none.
- R3: `ref_in` may be raised just before clock edge k. `stamp_valid` is then still 0 after edge k+1 and becomes 1 after edge k+2.
- R4: The stored timestamp equals the counter value present in the cycle before the capture edge. After reset the counter starts at 0. Its prescaler starts at 0 and issues a tick on each clock where it is greater than or equal to `cfg_prescale`, then restarts at 0; otherwise it increments. The counter advances by one only on ticks.
- R5: On a tick, a counter that is greater than or equal to `cfg_limit` goes to 0. A captured value is therefore never above `cfg_limit` once the counter has wrapped under that limit.
- R6: A clock with `rd_en` high while `stamp_valid` is 1, and no capture in that clock, clears `stamp_valid` on the next cycle. `stamp_value` changes only on a capture.
- R7: A capture while `stamp_valid` is 1 and `rd_en` is 0 sets `over_capture` and replaces `stamp_value` with the newer timestamp.
- R8: `over_capture` stays 1 through reads and further captures until a clock with `ovr_clr` high, after which it reads 0.
- R9: A capture in the same clock as a read leaves `stamp_valid` at 1 with the new value and does not set `over_capture`.
- R10: `rd_en` while `stamp_valid` is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference input to be stamped |
| cfg_prescale | input | PRE_W | Tick every cfg_prescale+1 clocks |
| cfg_limit | input | CNT_W | Highest counter value before wrap |
| rd_en | input | 1 | Read strobe, consumes the pending timestamp |
| ovr_clr | input | 1 | Clears the sticky over-capture flag |
| stamp_valid | output | 1 | An unread timestamp is held |
| stamp_value | output | CNT_W | Captured counter value |
| over_capture | output | 1 | Sticky flag, an unread timestamp was overwritten |

## Verification
Faults in the synchronizer or in the edge detector appear as a valid flag one clock early or late. They can also appear as extra captures while the input level is held. Both show within three clocks of an input change. A prescaler or wrap fault does not show at once. It becomes visible only as a wrong timestamp value on the next read, so the bench keeps its own counter model and compares every popped value. Flag priority faults in the read/capture collision show on the very next cycle: a valid flag that drops, or an over-capture flag that rises when it should not.

// File: rtl/ets_pkg.sv
`timescale 1ns/1ps
package ets_pkg;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_PRE_W  = 8;
  localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/ets_sync_edge.sv
`timescale 1ns/1ps
module ets_sync_edge #(
  parameter int unsigned STAGES = ets_pkg::DEF_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] sh_q;
  logic [LAST:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // rising edge seen between the last synchronized stage and its delayed copy
  assign rise = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/ets_tick_counter.sv
`timescale 1ns/1ps
module ets_tick_counter #(
  parameter int unsigned CNT_W = ets_pkg::DEF_CNT_W,
  parameter int unsigned PRE_W = ets_pkg::DEF_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [CNT_W-1:0] cfg_limit,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (pre_q >= cfg_prescale);
    pre_d = tick ? '0 : pre_q + 1'b1;
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q >= cfg_limit) cnt_d = '0;
      else                    cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ets_capture.sv
`timescale 1ns/1ps
module ets_capture #(
  parameter int unsigned CNT_W = ets_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rd_en,
  input  logic             ovr_clr,
  output logic             valid,
  output logic [CNT_W-1:0] value,
  output logic             ovr
);
  logic             valid_q, valid_d;
  logic             ovr_q, ovr_d;
  logic [CNT_W-1:0] val_q;

  always_comb begin
    valid_d = valid_q;
    if (rd_en) valid_d = 1'b0;
    if (cap)   valid_d = 1'b1;
    ovr_d = ovr_q;
    if (ovr_clr) ovr_d = 1'b0;
    if (cap && valid_q && !rd_en) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val_q <= '0;
    else if (cap) val_q <= cnt;
  end

  assign valid = valid_q;
  assign value = val_q;
  assign ovr   = ovr_q;
endmodule

// File: rtl/ref_edge_timestamper.sv
`timescale 1ns/1ps
module ref_edge_timestamper #(
  parameter int unsigned CNT_W  = ets_pkg::DEF_CNT_W,
  parameter int unsigned PRE_W  = ets_pkg::DEF_PRE_W,
  parameter int unsigned STAGES = ets_pkg::DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             rd_en,
  input  logic             ovr_clr,
  output logic             stamp_valid,
  output logic [CNT_W-1:0] stamp_value,
  output logic             over_capture
);
  logic             rise;
  logic             tick;
  logic [CNT_W-1:0] cnt_now;

  ets_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ref_in), .rise(rise)
  );

  ets_tick_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale),
    .cfg_limit(cfg_limit), .tick(tick), .cnt(cnt_now)
  );

  ets_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(rise), .cnt(cnt_now),
    .rd_en(rd_en), .ovr_clr(ovr_clr), .valid(stamp_valid),
    .value(stamp_value), .ovr(over_capture)
  );
endmodule

// File: rtl/ets_checker.sv
`timescale 1ns/1ps
module ets_checker #(
  parameter int unsigned CNT_W = ets_pkg::DEF_CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             ovr_clr,
  input logic             rise,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_now,
  input logic [CNT_W-1:0] cfg_limit,
  input logic             stamp_valid,
  input logic [CNT_W-1:0] stamp_value,
  input logic             over_capture
);
  // R3
  edge_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> stamp_valid);
  // R6
  read_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stamp_valid && !rise) |=> !stamp_valid);
  // R6
  value_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(stamp_value));
  // R7
  overwrite_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && stamp_valid && !rd_en) |=> over_capture);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over_capture && !ovr_clr) |=> over_capture);
  // R9
  collide_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && rd_en && !over_capture && !ovr_clr) |=> (stamp_valid && !over_capture));
  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_now >= cfg_limit) |=> (cnt_now == '0));
  // R2
  valid_rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stamp_valid) |-> $past(rise));
endmodule

bind ref_edge_timestamper ets_checker #(.CNT_W(CNT_W)) u_ets_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .ovr_clr(ovr_clr), .rise(rise),
  .tick(tick), .cnt_now(cnt_now), .cfg_limit(cfg_limit),
  .stamp_valid(stamp_valid), .stamp_value(stamp_value),
  .over_capture(over_capture)
);

// File: tb/test_ref_edge_timestamper.sv
`timescale 1ns/1ps
module test_ref_edge_timestamper;
  localparam int CW = 16;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ref_in;
  logic [PW-1:0] cfg_prescale;
  logic [CW-1:0] cfg_limit;
  logic          rd_en;
  logic          ovr_clr;
  logic          stamp_valid;
  logic [CW-1:0] stamp_value;
  logic          over_capture;

  always #10 clk = ~clk;

  ref_edge_timestamper #(.CNT_W(CW), .PRE_W(PW)) i_ref_edge_timestamper (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .cfg_prescale(cfg_prescale),
    .cfg_limit(cfg_limit), .rd_en(rd_en), .ovr_clr(ovr_clr),
    .stamp_valid(stamp_valid), .stamp_value(stamp_value),
    .over_capture(over_capture)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [CW-1:0] exp_q[$];

  // reference counter built from R4/R5
  logic [PW-1:0] m_pre;
  logic [CW-1:0] m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= '0;
      m_cnt <= '0;
    end else if (m_pre >= cfg_prescale) begin
      m_pre <= '0;
      m_cnt <= (m_cnt >= cfg_limit) ? '0 : m_cnt + 1'b1;
    end else begin
      m_pre <= m_pre + 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: makes a fresh rising edge and predicts its timestamp;
  // returns between edge k+1 and edge k+2
  task automatic drive_edge();
    @(negedge clk) ref_in = 1'b0;
    repeat (3) @(negedge clk);
    ref_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 exp_q.push_back(m_cnt);
  endtask

  // monitor side: pops the expected value and compares at read time
  task automatic pop_read(input string req);
    logic [CW-1:0] e;
    @(negedge clk);
    chk({req, " valid"}, stamp_valid, 1);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
    chk(req, stamp_value, e);
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    chk("R6 valid cleared", stamp_valid, 0);
    chk("R6 value held", stamp_value, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] v;
    rst_n = 1'b0; ref_in = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
    cfg_prescale = 8'd0; cfg_limit = 16'd1000;
    repeat (3) @(negedge clk);
    chk("R1 valid", stamp_valid, 0);
    chk("R1 ovr", over_capture, 0);
    chk("R1 value", stamp_value, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 valid after release", stamp_valid, 0);

    // R3 latency and R4 value
    drive_edge();
    @(negedge clk) chk("R3 not before k+2", stamp_valid, 0);
    @(negedge clk) chk("R3 valid after k+2", stamp_valid, 1);
    pop_read("R4 direct");

    // R2 held level and falling edge
    repeat (8) @(negedge clk);
    chk("R2 held high no capture", stamp_valid, 0);
    ref_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 falling no capture", stamp_valid, 0);

    // R10 read with nothing pending
    v = stamp_value;
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    chk("R10 valid", stamp_valid, 0);
    chk("R10 value", stamp_value, v);
    chk("R10 ovr", over_capture, 0);

    // R4 with prescaler
    cfg_prescale = 8'd3;
    for (int i = 0; i < 3; i++) begin
      drive_edge();
      repeat (2) @(negedge clk);
      pop_read("R4 prescaled");
      repeat (i * 5 + 2) @(negedge clk);
    end

    // R5 wrap at a small limit
    cfg_prescale = 8'd0;
    cfg_limit = 16'd5;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      drive_edge();
      repeat (2) @(negedge clk);
      chk("R5 within limit", (stamp_value <= 16'd5), 1);
      pop_read("R5 wrapped value");
      repeat (i + 1) @(negedge clk);
    end
    cfg_limit = 16'd1000;

    // R7 overwrite, R8 sticky
    drive_edge();
    repeat (2) @(negedge clk);
    drive_edge();
    @(negedge clk);
    chk("R7 ovr not yet", over_capture, 0);
    @(negedge clk);
    chk("R7 ovr set", over_capture, 1);
    void'(exp_q.pop_front());
    pop_read("R7 newest kept");
    chk("R8 ovr survives read", over_capture, 1);
    ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    chk("R8 ovr cleared", over_capture, 0);

    // R9 capture collides with read
    drive_edge();
    repeat (2) @(negedge clk);
    drive_edge();
    @(negedge clk);
    v = exp_q.pop_front();
    chk("R9 old value read", stamp_value, v);
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    chk("R9 valid kept", stamp_valid, 1);
    chk("R9 no ovr", over_capture, 0);
    pop_read("R9 new value");

    @(negedge clk) ref_in = 1'b0;
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule